// File: doc/BRIEF.md
# Prioritized Interrupt Delivery Arbiter

This block sits between a processor's asynchronous interrupt sources and its exception entry logic. It keeps one pending bit per source. When the core asks to take an interrupt, it selects the highest-priority source whose enable condition currently holds and, one clock later, reports that choice as a one-hot code with a valid strobe. Enable conditions come from the machine state bits (external enable, critical enable, hypervisor state, problem state) and from partition-control bits. Edge-type sources lose their pending bit when delivered. Level-type sources stay pending for as long as their input is high.

The block also tracks a power-save wake flag. A power-management instruction arms the flag. While it is armed, every asynchronous source counts as allowed, and any delivery except a machine check is reported as a system reset. That reset carries a 4-bit code naming the real cause, together with a resumed-from-doze flag. A take request made while the flag is armed but with nothing deliverable raises an error pulse, so the core is not silently left in the power-save path.

Top module: `irq_arbiter`

## Requirements
- R1: Sources are ranked by index, and index 0 wins. Code bit positions are: 0 reset, 1 machine check, 2 hypervisor decrementer, 3 hypervisor virtualization, 4 external, 5 critical external, 6 watchdog, 7 critical doorbell, 8 fixed-interval timer, 9 programmable interval timer, 10 decrementer, 11 doorbell, 12 hypervisor doorbell, 13 performance monitor, 14 thermal. A valid delivery always has exactly one bit of `dlv_code` set.
- R2: Reset (0) and machine check (1) are delivered whatever the enable bits are, and their pending bits clear on delivery.
- R3: Define async-allowed as `st_ee` OR the wake flag. Sources 6 to 14 are delivered only while async-allowed is true.
- R4: The hypervisor decrementer needs `pc_hdec_en`, plus either async-allowed or `st_hv`=0. Its pending bit clears on delivery.
- R5: Hypervisor virtualization needs `pc_hvirt_en`, plus either async-allowed or `st_hv`=0. It is level-held: pending equals `irq_in[3]`, and delivery does not clear it.
- R6: External (level-held, pending equals `irq_in[4]`) is deliverable in two cases. The first is async-allowed while NOT (`pc_hext_blk` AND `st_hv` AND NOT `st_pr`). The second is `hv_present` AND NOT `st_hv` AND NOT `pc_ext_guest`.
- R7: Critical external (level-held, pending equals `irq_in[5]`) is gated by `st_ce` alone.
- R8: For edge sources, a high `irq_in` bit sets the pending bit. The decrementer clears on delivery only when `dec_clr_cfg`=1, and otherwise clears through `dec_drop`. All other edge sources clear on delivery. A set in the same cycle as a clear leaves the bit set.
- R9: A `pm_enter` pulse discards a pending hypervisor decrementer. It arms the wake flag unless `pm_stop_form`=1 and `pm_exit_en`=0, in which case it clears the flag.
- R10: With the wake flag armed, a delivery other than machine check reports code bit 0, and `wake_reason` is: reset 4, external 8, decrementer 6, doorbell 5, hypervisor doorbell 3, hypervisor virtualization 9, any other source 0. A machine check keeps its own code with reason 0. Every delivery in this state sets `doze_resume` and disarms the flag.
- R11: A take with the wake flag armed and nothing deliverable pulses `wake_err` instead of `dlv_valid`, and leaves the flag armed.
- R12: All outputs are registered. They change only in the cycle after `take` and are zero in the other cycles. A take with nothing deliverable and the flag clear produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 15 | Per-source set pulse (edge sources) or level (sources 3, 4, 5) |
| dec_drop | input | 1 | Clears the latched decrementer request |
| take | input | 1 | Core requests one interrupt decision |
| st_ee | input | 1 | External-enable machine state bit |
| st_ce | input | 1 | Critical-enable machine state bit |
| st_hv | input | 1 | Processor is in hypervisor state |
| st_pr | input | 1 | Processor is in problem state |
| pc_hdec_en | input | 1 | Partition enable for the hypervisor decrementer |
| pc_hvirt_en | input | 1 | Partition enable for hypervisor virtualization |
| pc_hext_blk | input | 1 | Blocks external delivery to the hypervisor |
| pc_ext_guest | input | 1 | Keeps externals at the guest level |
| hv_present | input | 1 | Hypervisor mode is implemented |
| dec_clr_cfg | input | 1 | Decrementer clears on delivery |
| pm_enter | input | 1 | Power-management instruction executed |
| pm_stop_form | input | 1 | The instruction is the stop form |
| pm_exit_en | input | 1 | Exit-criterion control for the stop form |
| dlv_valid | output | 1 | Delivery strobe |
| dlv_code | output | 15 | One-hot delivered interrupt |
| wake_reason | output | 4 | Encoded wake cause |
| doze_resume | output | 1 | Delivery resumed from power save |
| wake_err | output | 1 | Wake armed but nothing deliverable |

## Verification
The hardest states to reach from the ports are the ones where the wake flag interacts with the pending state. Two cases stand out. The first is a hypervisor decrementer that would outrank the real wake cause but was discarded by `pm_enter`. The second is an armed flag meeting an empty pending vector, which must raise the error and then still let a machine check through with its own code. The stimulus reaches these by latching the decrementer and a doorbell before pulsing `pm_enter`, with `st_ee` low. It then checks that a doorbell reason comes out and that the same doorbell is refused afterwards because the flag has disarmed. A stop-form entry with the exit control set, followed by a take on an empty vector, covers the error path.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int NSRC = 15;
  localparam int IDXW = $clog2(NSRC);
  localparam int RSNW = 4;

  localparam int S_RST   = 0;
  localparam int S_MCK   = 1;
  localparam int S_HDEC  = 2;
  localparam int S_HVIRT = 3;
  localparam int S_EXT   = 4;
  localparam int S_CEXT  = 5;
  localparam int S_WDT   = 6;
  localparam int S_CDB   = 7;
  localparam int S_FIT   = 8;
  localparam int S_PIT   = 9;
  localparam int S_DEC   = 10;
  localparam int S_DB    = 11;
  localparam int S_HDB   = 12;
  localparam int S_PERF  = 13;
  localparam int S_THRM  = 14;

  // sources whose pending state is the input level itself
  localparam logic [NSRC-1:0] LEVEL_SRC = 15'b000_0000_0011_1000;
  localparam logic [NSRC-1:0] RST_BIT   = {{(NSRC-1){1'b0}}, 1'b1};

  function automatic logic [RSNW-1:0] wake_code(input logic [IDXW-1:0] idx);
    case (int'(idx))
      S_RST:   wake_code = 4'h4;
      S_EXT:   wake_code = 4'h8;
      S_DEC:   wake_code = 4'h6;
      S_DB:    wake_code = 4'h5;
      S_HDB:   wake_code = 4'h3;
      S_HVIRT: wake_code = 4'h9;
      default: wake_code = 4'h0;
    endcase
  endfunction
endpackage

// File: rtl/irq_gate.sv
module irq_gate import irq_arb_pkg::*; (
  input  logic [NSRC-1:0] pend,
  input  logic            wake,
  input  logic            st_ee,
  input  logic            st_ce,
  input  logic            st_hv,
  input  logic            st_pr,
  input  logic            pc_hdec_en,
  input  logic            pc_hvirt_en,
  input  logic            pc_hext_blk,
  input  logic            pc_ext_guest,
  input  logic            hv_present,
  output logic [NSRC-1:0] elig
);
  logic async_ok;
  logic ext_hv_blocked;

  always_comb begin
    async_ok       = st_ee | wake;
    ext_hv_blocked = pc_hext_blk & st_hv & ~st_pr;
    elig           = '0;
    elig[S_RST]    = pend[S_RST];
    elig[S_MCK]    = pend[S_MCK];
    elig[S_HDEC]   = pend[S_HDEC]  & pc_hdec_en  & (async_ok | ~st_hv);
    elig[S_HVIRT]  = pend[S_HVIRT] & pc_hvirt_en & (async_ok | ~st_hv);
    elig[S_EXT]    = pend[S_EXT] & ((async_ok & ~ext_hv_blocked) |
                                    (hv_present & ~st_hv & ~pc_ext_guest));
    elig[S_CEXT]   = pend[S_CEXT] & st_ce;
    for (int i = S_WDT; i < NSRC; i++) begin
      elig[i] = pend[i] & async_ok;
    end
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick import irq_arb_pkg::*; (
  input  logic [NSRC-1:0] elig,
  input  logic            wake,
  output logic [NSRC-1:0] sel,
  output logic            any,
  output logic [NSRC-1:0] code,
  output logic [RSNW-1:0] reason
);
  logic [IDXW-1:0] idx;

  always_comb begin
    sel = '0;
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (elig[i] && !any) begin
        sel[i] = 1'b1;
        any    = 1'b1;
        idx    = IDXW'(i);
      end
    end
    // while waking, everything but a machine check enters as a reset
    code   = (wake && !sel[S_MCK]) ? RST_BIT : sel;
    reason = wake ? wake_code(idx) : '0;
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter import irq_arb_pkg::*; (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] irq_in,
  input  logic            dec_drop,
  input  logic            take,
  input  logic            st_ee,
  input  logic            st_ce,
  input  logic            st_hv,
  input  logic            st_pr,
  input  logic            pc_hdec_en,
  input  logic            pc_hvirt_en,
  input  logic            pc_hext_blk,
  input  logic            pc_ext_guest,
  input  logic            hv_present,
  input  logic            dec_clr_cfg,
  input  logic            pm_enter,
  input  logic            pm_stop_form,
  input  logic            pm_exit_en,
  output logic            dlv_valid,
  output logic [NSRC-1:0] dlv_code,
  output logic [RSNW-1:0] wake_reason,
  output logic            doze_resume,
  output logic            wake_err
);
  logic [NSRC-1:0] pend;
  logic [NSRC-1:0] elig;
  logic [NSRC-1:0] sel;
  logic [NSRC-1:0] code;
  logic [RSNW-1:0] reason;
  logic            any;
  logic            wake_q;
  logic            fire;

  assign fire = take & any;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (LEVEL_SRC[i]) begin : g_lvl
      assign pend[i] = irq_in[i];
    end else begin : g_edge
      logic q;
      logic clr;
      always_comb begin
        clr = take & sel[i];
        if (i == S_DEC)  clr = (take & sel[i] & dec_clr_cfg) | dec_drop;
        if (i == S_HDEC) clr = clr | pm_enter;
      end
      always_ff @(posedge clk) begin
        if (rst)            q <= 1'b0;
        else if (irq_in[i]) q <= 1'b1;
        else if (clr)       q <= 1'b0;
      end
      assign pend[i] = q;
      // R8
      set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(irq_in[i])) |-> q);
    end
  end

  irq_gate u_gate (
    .pend(pend), .wake(wake_q), .st_ee(st_ee), .st_ce(st_ce),
    .st_hv(st_hv), .st_pr(st_pr), .pc_hdec_en(pc_hdec_en),
    .pc_hvirt_en(pc_hvirt_en), .pc_hext_blk(pc_hext_blk),
    .pc_ext_guest(pc_ext_guest), .hv_present(hv_present), .elig(elig)
  );

  irq_pick u_pick (
    .elig(elig), .wake(wake_q), .sel(sel), .any(any),
    .code(code), .reason(reason)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dlv_valid   <= 1'b0;
      dlv_code    <= '0;
      wake_reason <= '0;
      doze_resume <= 1'b0;
      wake_err    <= 1'b0;
      wake_q      <= 1'b0;
    end else begin
      dlv_valid   <= fire;
      dlv_code    <= fire ? code : '0;
      wake_reason <= fire ? reason : '0;
      doze_resume <= fire & wake_q;
      wake_err    <= take & ~any & wake_q;
      if (pm_enter)  wake_q <= ~(pm_stop_form & ~pm_exit_en);
      else if (fire) wake_q <= 1'b0;
    end
  end

  // R12
  valid_after_take_chk: assert property (@(posedge clk) disable iff (rst)
    (dlv_valid || wake_err) |-> $past(take));
  // R1
  one_code_chk: assert property (@(posedge clk) disable iff (rst)
    dlv_valid |-> ($countones(dlv_code) == 1));
  // R11
  err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    wake_err |-> !dlv_valid);
  // R10
  reason_doze_chk: assert property (@(posedge clk) disable iff (rst)
    (wake_reason != '0) |-> doze_resume);
  // R3
  wdt_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (dlv_valid && dlv_code[S_WDT]) |-> $past(st_ee));
  // R7
  cext_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (dlv_valid && dlv_code[S_CEXT]) |-> $past(st_ce));
endmodule

// File: tb/irq_arbiter_bench.sv
module irq_arbiter_bench;
  import irq_arb_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NSRC-1:0] irq_in = '0;
  logic dec_drop = 0, take = 0;
  logic st_ee = 0, st_ce = 0, st_hv = 0, st_pr = 0;
  logic pc_hdec_en = 0, pc_hvirt_en = 0, pc_hext_blk = 0, pc_ext_guest = 0;
  logic hv_present = 0, dec_clr_cfg = 0;
  logic pm_enter = 0, pm_stop_form = 0, pm_exit_en = 0;
  logic dlv_valid, doze_resume, wake_err;
  logic [NSRC-1:0] dlv_code;
  logic [RSNW-1:0] wake_reason;

  always #10 clk = ~clk;

  irq_arbiter u_irq_arbiter (.*);

  typedef struct {
    logic            valid;
    logic [NSRC-1:0] code;
    logic [RSNW-1:0] rsn;
    logic            doze;
    logic            err;
    string           tag;
  } exp_t;

  exp_t sb[$];
  int n_cmp = 0;
  int n_bad = 0;
  logic take_q = 1'b0;

  always @(posedge clk) take_q <= take;

  always @(negedge clk) begin
    exp_t e;
    if (take_q && !rst) begin
      if (sb.size() == 0) begin
        n_bad++;
        $display("FAIL scoreboard empty: got valid=%0b code=%h exp nothing queued", dlv_valid, dlv_code);
      end else begin
        e = sb.pop_front();
        n_cmp++;
        if (dlv_valid !== e.valid || dlv_code !== e.code || wake_reason !== e.rsn ||
            doze_resume !== e.doze || wake_err !== e.err) begin
          n_bad++;
          $display("FAIL %s: got v=%0b code=%h rsn=%h doze=%0b err=%0b exp v=%0b code=%h rsn=%h doze=%0b err=%0b",
                   e.tag, dlv_valid, dlv_code, wake_reason, doze_resume, wake_err,
                   e.valid, e.code, e.rsn, e.doze, e.err);
        end
      end
    end
  end

  // src < 0 means nothing delivered
  task automatic expect_take(input int src, input logic [3:0] rsn, input logic doze,
                             input logic err, input string tag);
    exp_t e;
    e.valid = (src >= 0);
    e.code  = (src >= 0) ? (RST_BIT << src) : '0;
    e.rsn   = rsn;
    e.doze  = doze;
    e.err   = err;
    e.tag   = tag;
    sb.push_back(e);
    take = 1'b1;
    @(posedge clk);
    @(negedge clk);
    take = 1'b0;
  endtask

  task automatic pulse(input int i);
    irq_in[i] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    irq_in[i] = 1'b0;
  endtask

  task automatic drop_dec();
    dec_drop = 1'b1;
    @(posedge clk);
    @(negedge clk);
    dec_drop = 1'b0;
  endtask

  task automatic pm(input logic stop, input logic ex);
    pm_stop_form = stop;
    pm_exit_en   = ex;
    pm_enter     = 1'b1;
    @(posedge clk);
    @(negedge clk);
    pm_enter = 1'b0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete, exp completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    n_cmp++;
    if (dlv_valid !== 0 || dlv_code !== '0 || wake_err !== 0 || doze_resume !== 0) begin
      n_bad++;
      $display("FAIL R12 reset state: got v=%0b code=%h err=%0b exp all zero", dlv_valid, dlv_code, wake_err);
    end
    rst = 1'b0;
    @(negedge clk);

    // R2 / R1: reset and machine check need no enables
    pulse(S_MCK); pulse(S_RST);
    expect_take(S_RST, 0, 0, 0, "R1 R2 reset outranks mcheck");
    expect_take(S_MCK, 0, 0, 0, "R2 mcheck ungated");
    expect_take(-1, 0, 0, 0, "R2 both cleared");

    // R3 async gating
    pulse(S_FIT);
    expect_take(-1, 0, 0, 0, "R3 fit blocked ee=0");
    st_ee = 1;
    expect_take(S_FIT, 0, 0, 0, "R3 fit with ee");
    expect_take(-1, 0, 0, 0, "R8 fit cleared");

    // R1 ordering among async sources, R8 decrementer held
    pulse(S_DEC); pulse(S_WDT); pulse(S_THRM);
    expect_take(S_WDT, 0, 0, 0, "R1 wdt first");
    expect_take(S_DEC, 0, 0, 0, "R1 dec next");
    expect_take(S_DEC, 0, 0, 0, "R8 dec held without clr cfg");
    drop_dec();
    expect_take(S_THRM, 0, 0, 0, "R8 dec dropped, thermal");
    expect_take(-1, 0, 0, 0, "R8 thermal cleared");
    dec_clr_cfg = 1;
    pulse(S_DEC);
    expect_take(S_DEC, 0, 0, 0, "R8 dec with clr cfg");
    expect_take(-1, 0, 0, 0, "R8 dec cleared on delivery");
    dec_clr_cfg = 0;

    // R4 hypervisor decrementer
    st_ee = 0;
    pulse(S_HDEC);
    expect_take(-1, 0, 0, 0, "R4 hdec needs enable");
    pc_hdec_en = 1; st_hv = 1;
    expect_take(-1, 0, 0, 0, "R4 hdec blocked hv no ee");
    st_hv = 0;
    expect_take(S_HDEC, 0, 0, 0, "R4 hdec outside hv");
    expect_take(-1, 0, 0, 0, "R4 hdec cleared");

    // R5 hypervisor virtualization level
    pc_hvirt_en = 1;
    irq_in[S_HVIRT] = 1;
    expect_take(S_HVIRT, 0, 0, 0, "R5 hvirt delivered");
    expect_take(S_HVIRT, 0, 0, 0, "R5 hvirt held");
    st_hv = 1;
    expect_take(-1, 0, 0, 0, "R5 hvirt blocked hv no ee");
    st_ee = 1;
    irq_in[S_EXT] = 1;
    expect_take(S_HVIRT, 0, 0, 0, "R5 R1 hvirt over ext");
    irq_in[S_HVIRT] = 0;

    // R6 external
    pc_hext_blk = 1;
    expect_take(-1, 0, 0, 0, "R6 ext blocked to hv");
    st_pr = 1;
    expect_take(S_EXT, 0, 0, 0, "R6 ext in problem state");
    st_pr = 0; pc_hext_blk = 0; st_ee = 0; st_hv = 0;
    expect_take(-1, 0, 0, 0, "R6 ext no path");
    hv_present = 1;
    expect_take(S_EXT, 0, 0, 0, "R6 ext guest path");
    pc_ext_guest = 1;
    expect_take(-1, 0, 0, 0, "R6 ext kept at guest");
    irq_in[S_EXT] = 0; hv_present = 0; pc_ext_guest = 0;

    // R7 critical external
    st_ee = 1;
    irq_in[S_CEXT] = 1;
    expect_take(-1, 0, 0, 0, "R7 cext needs ce");
    st_ce = 1; st_ee = 0;
    expect_take(S_CEXT, 0, 0, 0, "R7 cext with ce only");
    expect_take(S_CEXT, 0, 0, 0, "R7 cext held");
    irq_in[S_CEXT] = 0; st_ce = 0;

    // R9 R10 wake discards hdec, doorbell reason
    pulse(S_HDEC); pulse(S_DB);
    pm(0, 0);
    expect_take(S_RST, 4'h5, 1, 0, "R9 R10 doorbell wake, hdec discarded");
    pulse(S_DB);
    expect_take(-1, 0, 0, 0, "R10 wake flag cleared");
    st_ee = 1;
    expect_take(S_DB, 0, 0, 0, "R3 doorbell normal");
    st_ee = 0;

    // R9 stop form without exit control; R11 error path
    pm(1, 0);
    pulse(S_DEC);
    expect_take(-1, 0, 0, 0, "R9 stop without exit no wake");
    drop_dec();
    pm(1, 1);
    expect_take(-1, 0, 0, 1, "R11 wake with nothing pending");
    pulse(S_MCK);
    expect_take(S_MCK, 0, 1, 0, "R10 mcheck keeps code on wake");

    // R10 reason codes
    pm(0, 0); irq_in[S_EXT] = 1;
    expect_take(S_RST, 4'h8, 1, 0, "R10 external reason");
    irq_in[S_EXT] = 0;
    pm(0, 0); pulse(S_DEC);
    expect_take(S_RST, 4'h6, 1, 0, "R10 decrementer reason");
    drop_dec();
    pm(0, 0); pulse(S_HDB);
    expect_take(S_RST, 4'h3, 1, 0, "R10 hyp doorbell reason");
    pm(0, 0); irq_in[S_HVIRT] = 1;
    expect_take(S_RST, 4'h9, 1, 0, "R10 hvirt reason");
    irq_in[S_HVIRT] = 0;
    pm(0, 0); pulse(S_RST);
    expect_take(S_RST, 4'h4, 1, 0, "R10 reset reason");
    pm(0, 0); pulse(S_PIT);
    expect_take(S_RST, 4'h0, 1, 0, "R10 uncoded source");

    // R8 set in same cycle as delivery clear
    st_ee = 1;
    pulse(S_WDT);
    irq_in[S_WDT] = 1;
    expect_take(S_WDT, 0, 0, 0, "R8 deliver with concurrent set");
    irq_in[S_WDT] = 0;
    expect_take(S_WDT, 0, 0, 0, "R8 set wins over clear");
    expect_take(-1, 0, 0, 0, "R8 cleared afterwards");

    // R12 no output without take
    pulse(S_WDT);
    repeat (3) @(negedge clk);
    n_cmp++;
    if (dlv_valid !== 0 || dlv_code !== '0) begin
      n_bad++;
      $display("FAIL R12 idle output: got v=%0b code=%h exp v=0 code=0", dlv_valid, dlv_code);
    end
    expect_take(S_WDT, 0, 0, 0, "R12 pending kept until take");

    repeat (2) @(negedge clk);
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard leftover: got %0d exp 0", sb.size());
    end
    finish_run();
  end
endmodule